// File: doc/BRIEF.md
# Background Multiply/Divide Unit with HI/LO Interlock

This block performs 32-bit integer multiplication and division next to an in-order pipeline. It keeps its own pair of result registers, HI and LO. An issued operation is accepted in one cycle and then computed over many cycles. During that time the pipeline keeps retiring unrelated instructions. Only an instruction that touches HI or LO is held back. Such an instruction sees the `stall` output and waits until the unit is idle again.

Multiplication adds several multiplier bits into a 64-bit accumulator per cycle. Division produces one quotient bit per cycle by restoring subtraction. A down-counter fixes the visible latency independently of the arithmetic, so the two latencies can be tuned without touching the datapath. An operation counts as committed when it is issued. A pipeline flush therefore leaves it running, and any later HI/LO access is interlocked in the usual way.

Top module: `muldiv_unit`

## Requirements
- R1: An operation is accepted in the cycle `issue_valid` is high; `busy` is high from the next cycle. `stall` stays low while busy as long as neither `rd_req` nor `wr_req` is asserted. `issue_op[1]` selects divide (1) or multiply (0), and `issue_op[0]` selects signed (1) or unsigned (0) operands.
- R2: `busy` stays high for exactly MUL_LAT cycles (default 12) after a multiply is issued and DIV_LAT cycles (default 35) after a divide. New HI/LO contents are readable in the first cycle `busy` is low.
- R3: `stall` is high whenever `rd_req` or `wr_req` is asserted while `busy` is high. It is low whenever `busy` is low.
- R4: `flush` does not cancel, delay or alter an operation in progress. A HI/LO access made after a flush still stalls while the operation runs.
- R5: A multiply writes the upper half of the 64-bit product to HI and the lower half to LO. The product is signed or unsigned according to `issue_op[0]`.
- R6: A divide with a nonzero divisor writes the quotient, truncated toward zero, to LO and the remainder to HI. In signed mode the remainder carries the dividend's sign.
- R7: A divide by zero finishes in the normal DIV_LAT cycles with LO all ones and HI equal to the dividend. No error is signalled.
- R8: A new issue while `busy` is high abandons the running operation. Latency and result then follow the new operation alone, counted from its own issue.
- R9: A write with `wr_req` high takes effect at the clock edge only when `busy` is low. `wr_sel` 1 targets HI and 0 targets LO. A write attempted while busy changes nothing.
- R10: `rd_data` shows HI when `rd_sel` is 1 and LO when it is 0. After reset both registers hold zero and `busy` is low.
- R11: HI and LO keep their previous values throughout a running operation until it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Start an operation this cycle |
| issue_op | input | 2 | [1] divide, [0] signed |
| issue_a | input | 32 | Multiplicand or dividend |
| issue_b | input | 32 | Multiplier or divisor |
| flush | input | 1 | Pipeline flush; no effect on the unit |
| rd_req | input | 1 | Pipeline wants to read HI or LO |
| rd_sel | input | 1 | 1 reads HI, 0 reads LO |
| rd_data | output | 32 | Selected result register |
| wr_req | input | 1 | Pipeline wants to write HI or LO |
| wr_sel | input | 1 | 1 writes HI, 0 writes LO |
| wr_data | input | 32 | Data for a direct write |
| busy | output | 1 | Operation in progress |
| stall | output | 1 | Hold the requesting HI/LO instruction |

## Verification
A corrupted latency count shows at the ports in one of two ways. `busy` may fall a cycle early or late, or a read released by `stall` may return stale or half-computed data. The bench therefore samples `busy` on both sides of the exact expected fall edge. A wrong iteration or sign-fixup state shows only when the operation completes, as a wrong HI or LO value. Such faults are caught by comparing against native wide arithmetic over sign mixes, extreme operands and the zero divisor. A lost abort, a flush that clears state, or a write accepted while busy corrupts HI/LO at completion and is caught there.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
    // Operation selector carried from issue into the datapath.
    typedef struct packed {
        logic is_div;
        logic is_signed;
    } md_op_t;
endpackage

// File: rtl/muldiv_seq.sv
// Latency sequencer: tracks busy and signals completion.
module muldiv_seq #(
    parameter int MUL_LAT = 12,
    parameter int DIV_LAT = 35,
    parameter int CNT_W   = $clog2(DIV_LAT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_is_div,
    input  logic flush,
    output logic busy,
    output logic done
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        done = s_q.busy && (s_q.cnt == '0) && !start;
        if (start) begin
            s_d.busy = 1'b1;
            s_d.cnt  = start_is_div ? CNT_W'(DIV_LAT - 1) : CNT_W'(MUL_LAT - 1);
        end else if (s_q.busy) begin
            if (s_q.cnt == '0) s_d.busy = 1'b0;
            else               s_d.cnt  = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;

    p_issue_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> s_q.busy);

    p_flush_no_cancel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && flush && !start && s_q.cnt != '0) |=> s_q.busy);

    p_done_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !s_q.busy);
endmodule

// File: rtl/muldiv_core.sv
// Iterative datapath: radix-2^MUL_RADIX multiply, restoring divide.
module muldiv_core
    import muldiv_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int MUL_RADIX = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  md_op_t            start_op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              busy,
    output logic [DATA_W-1:0] hi_res,
    output logic [DATA_W-1:0] lo_res
);
    localparam int ACC_W     = 2 * DATA_W;
    localparam int MUL_STEPS = DATA_W / MUL_RADIX;
    localparam int DIV_STEPS = DATA_W;
    localparam int IT_W      = $clog2(DIV_STEPS + 1);

    typedef struct packed {
        md_op_t            op;
        logic [DATA_W-1:0] a_raw;
        logic [DATA_W-1:0] b_mag;
        logic [ACC_W-1:0]  mcand;
        logic [DATA_W-1:0] mplier;
        logic [ACC_W-1:0]  acc;
        logic              neg_q;
        logic              neg_r;
        logic              div0;
        logic [IT_W-1:0]   iter;
    } core_t;

    core_t c_d, c_q;

    logic              a_neg, b_neg;
    logic [DATA_W-1:0] a_mag, b_mag;
    logic [DATA_W:0]   rem_w;
    logic [DATA_W-1:0] quo_w;
    logic [IT_W-1:0]   step_lim;

    always_comb begin
        a_neg    = start_op.is_signed && opa[DATA_W-1];
        b_neg    = start_op.is_signed && opb[DATA_W-1];
        a_mag    = a_neg ? (~opa + 1'b1) : opa;
        b_mag    = b_neg ? (~opb + 1'b1) : opb;
        step_lim = c_q.op.is_div ? IT_W'(DIV_STEPS) : IT_W'(MUL_STEPS);
        rem_w    = c_q.acc[ACC_W-1:DATA_W-1];
        quo_w    = {c_q.acc[DATA_W-2:0], 1'b0};
        c_d      = c_q;
        if (start) begin
            c_d.op     = start_op;
            c_d.a_raw  = opa;
            c_d.b_mag  = b_mag;
            c_d.mcand  = {{DATA_W{1'b0}}, a_mag};
            c_d.mplier = b_mag;
            c_d.acc    = start_op.is_div ? {{DATA_W{1'b0}}, a_mag} : '0;
            c_d.neg_q  = a_neg ^ b_neg;
            c_d.neg_r  = a_neg;
            c_d.div0   = (opb == '0);
            c_d.iter   = '0;
        end else if (busy && (c_q.iter < step_lim)) begin
            c_d.iter = c_q.iter + 1'b1;
            if (c_q.op.is_div) begin
                if (rem_w >= {1'b0, c_q.b_mag}) begin
                    rem_w    = rem_w - {1'b0, c_q.b_mag};
                    quo_w[0] = 1'b1;
                end
                c_d.acc = {rem_w[DATA_W-1:0], quo_w};
            end else begin
                c_d.acc    = c_q.acc + c_q.mcand * ACC_W'(c_q.mplier[MUL_RADIX-1:0]);
                c_d.mcand  = c_q.mcand << MUL_RADIX;
                c_d.mplier = c_q.mplier >> MUL_RADIX;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    logic [ACC_W-1:0]  prod;
    logic [DATA_W-1:0] q_mag, r_mag;

    always_comb begin
        prod  = c_q.neg_q ? (~c_q.acc + 1'b1) : c_q.acc;
        q_mag = c_q.acc[DATA_W-1:0];
        r_mag = c_q.acc[ACC_W-1:DATA_W];
        if (!c_q.op.is_div) begin
            hi_res = prod[ACC_W-1:DATA_W];
            lo_res = prod[DATA_W-1:0];
        end else if (c_q.div0) begin
            hi_res = c_q.a_raw;
            lo_res = '1;
        end else begin
            hi_res = c_q.neg_r ? (~r_mag + 1'b1) : r_mag;
            lo_res = c_q.neg_q ? (~q_mag + 1'b1) : q_mag;
        end
    end

    p_iter_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.iter <= IT_W'(DIV_STEPS));

    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (c_q.iter == '0));
endmodule

// File: rtl/muldiv_unit.sv
// Top: HI/LO registers, direct access and interlock.
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int MUL_LAT   = 12,
    parameter int DIV_LAT   = 35,
    parameter int MUL_RADIX = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [1:0]        issue_op,
    input  logic [DATA_W-1:0] issue_a,
    input  logic [DATA_W-1:0] issue_b,
    input  logic              flush,
    input  logic              rd_req,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_req,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              stall
);
    localparam int CNT_W = $clog2(((MUL_LAT > DIV_LAT) ? MUL_LAT : DIV_LAT) + 1);

    typedef struct packed {
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
    } hilo_t;

    hilo_t             r_d, r_q;
    md_op_t            op_in;
    logic              done;
    logic [DATA_W-1:0] hi_res, lo_res;

    assign op_in = md_op_t'(issue_op);

    muldiv_seq #(
        .MUL_LAT (MUL_LAT),
        .DIV_LAT (DIV_LAT),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (issue_valid),
        .start_is_div (op_in.is_div),
        .flush        (flush),
        .busy         (busy),
        .done         (done)
    );

    muldiv_core #(
        .DATA_W    (DATA_W),
        .MUL_RADIX (MUL_RADIX)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (issue_valid),
        .start_op (op_in),
        .opa      (issue_a),
        .opb      (issue_b),
        .busy     (busy),
        .hi_res   (hi_res),
        .lo_res   (lo_res)
    );

    always_comb begin
        r_d = r_q;
        if (done) begin
            r_d.hi = hi_res;
            r_d.lo = lo_res;
        end else if (wr_req && !busy) begin
            if (wr_sel) r_d.hi = wr_data;
            else        r_d.lo = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_data = rd_sel ? r_q.hi : r_q.lo;
    assign stall   = busy && (rd_req || wr_req);

    p_hold_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(r_q));

    p_write_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_sel && !busy) |=> (r_q.hi == $past(wr_data)));

    p_idle_no_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !stall);
endmodule

// File: tb/muldiv_unit_bench.sv
`timescale 1ns/1ps
module muldiv_unit_bench;
    localparam int MUL_LAT = 12;
    localparam int DIV_LAT = 35;
    localparam int NVEC    = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [1:0]  issue_op = '0;
    logic [31:0] issue_a = '0, issue_b = '0;
    logic        flush = 1'b0, rd_req = 1'b0, rd_sel = 1'b0;
    logic        wr_req = 1'b0, wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        busy, stall;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    muldiv_unit u_muldiv_unit (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_a(issue_a), .issue_b(issue_b), .flush(flush), .rd_req(rd_req),
        .rd_sel(rd_sel), .rd_data(rd_data), .wr_req(wr_req), .wr_sel(wr_sel),
        .wr_data(wr_data), .busy(busy), .stall(stall)
    );

    // {op[1:0] (1=div,0=signed), a, b}
    localparam logic [65:0] VEC [NVEC] = '{
        {2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {2'b00, 32'h0000_0003, 32'h0000_0005},
        {2'b01, 32'hFFFF_FFF9, 32'h0000_0006},
        {2'b01, 32'h8000_0000, 32'h8000_0000},
        {2'b00, 32'h1234_5678, 32'h9ABC_DEF0},
        {2'b10, 32'd100,       32'd7},
        {2'b10, 32'hFFFF_FFFF, 32'h0000_0010},
        {2'b11, 32'hFFFF_FF9C, 32'd7},
        {2'b11, 32'd100,       32'hFFFF_FFF9},
        {2'b11, 32'hFFFF_FF9C, 32'hFFFF_FFF9},
        {2'b11, 32'h8000_0000, 32'hFFFF_FFFF},
        {2'b10, 32'd5,         32'd9}
    };

    function automatic logic [63:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic is_div, input logic sg);
        logic signed [63:0] sa, sb, p, q, r;
        sa = sg ? {{32{a[31]}}, a} : {32'b0, a};
        sb = sg ? {{32{b[31]}}, b} : {32'b0, b};
        if (!is_div) begin
            p = sa * sb;
            return p;
        end
        if (b == 32'b0) return {a, 32'hFFFF_FFFF};
        q = sa / sb;
        r = sa % sb;
        return {r[31:0], q[31:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_reg(input logic sel, output logic [31:0] v);
        rd_sel = sel;
        #0.5;
        v = rd_data;
    endtask

    // Drive an issue that is sampled at the next rising edge; return 1 ns after it.
    task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
        issue_valid = 1'b1; issue_op = op; issue_a = a; issue_b = b;
        @(posedge clk); #1;
        issue_valid = 1'b0;
    endtask

    // Wait out the latency after an issue edge; check busy edge and the result.
    task automatic finish_op(input int lat, input logic [63:0] exp, input string tag);
        logic [31:0] v;
        repeat (lat - 1) @(posedge clk);
        #1 chk({tag, " R2 busy before end"}, {31'b0, busy}, 32'd1);
        @(posedge clk); #1;
        chk({tag, " R2 busy low at end"}, {31'b0, busy}, 32'd0);
        read_reg(1'b1, v); chk({tag, " HI R10"}, v, exp[63:32]);
        read_reg(1'b0, v); chk({tag, " LO R10"}, v, exp[31:0]);
    endtask

    task automatic write_reg(input logic sel, input logic [31:0] d);
        wr_req = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk); #1;
        wr_req = 1'b0;
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            nerr++; nchk++;
            $display("FAIL watchdog R2 actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [63:0] e;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R10 reset state, R3 idle access does not stall
        rd_req = 1'b1;
        #0.5 chk("reset busy R10", {31'b0, busy}, 32'd0);
        chk("idle read no stall R3", {31'b0, stall}, 32'd0);
        read_reg(1'b1, v); chk("reset HI R10", v, 32'd0);
        read_reg(1'b0, v); chk("reset LO R10", v, 32'd0);
        rd_req = 1'b0;

        // Table: R5 multiply, R6 divide
        for (int i = 0; i < NVEC; i++) begin
            logic [65:0] t;
            t = VEC[i];
            e = model(t[63:32], t[31:0], t[65], t[64]);
            @(negedge clk);
            issue(t[65:64], t[63:32], t[31:0]);
            finish_op(t[65] ? DIV_LAT : MUL_LAT, e, t[65] ? "vector R6" : "vector R5");
        end

        // R9 direct writes while idle
        @(negedge clk);
        write_reg(1'b1, 32'hAAAA_5555);
        write_reg(1'b0, 32'h0000_1234);
        read_reg(1'b1, v); chk("idle write HI R9", v, 32'hAAAA_5555);
        read_reg(1'b0, v); chk("idle write LO R9", v, 32'h0000_1234);

        // R1/R3/R11/R9 behaviour during a running multiply
        @(negedge clk);
        issue(2'b00, 32'd3, 32'd5);
        chk("busy after issue R1", {31'b0, busy}, 32'd1);
        chk("no access no stall R1", {31'b0, stall}, 32'd0);
        rd_req = 1'b1;
        read_reg(1'b1, v);
        chk("read while busy stalls R3", {31'b0, stall}, 32'd1);
        chk("HI held while busy R11", v, 32'hAAAA_5555);
        rd_req = 1'b0;
        wr_req = 1'b1; wr_sel = 1'b0; wr_data = 32'hDEAD_BEEF;
        #0.5 chk("write while busy stalls R3", {31'b0, stall}, 32'd1);
        @(posedge clk); #1;
        wr_req = 1'b0;
        read_reg(1'b0, v); chk("busy write ignored R9", v, 32'h0000_1234);
        finish_op(MUL_LAT - 1, 64'd15, "mul after busy write R9");

        // R4 flush does not cancel; later read still stalls
        @(negedge clk);
        issue(2'b11, 32'hFFFF_FF9C, 32'd7);
        repeat (2) @(posedge clk);
        #1 flush = 1'b1;
        @(posedge clk); #1 flush = 1'b0;
        chk("busy kept after flush R4", {31'b0, busy}, 32'd1);
        rd_req = 1'b1;
        #0.5 chk("read after flush stalls R4", {31'b0, stall}, 32'd1);
        rd_req = 1'b0;
        finish_op(DIV_LAT - 3, model(32'hFFFF_FF9C, 32'd7, 1'b1, 1'b1), "flushed div R4");

        // R7 divide by zero, signed and unsigned
        @(negedge clk);
        issue(2'b11, 32'hFFFF_FFEC, 32'd0);
        finish_op(DIV_LAT, {32'hFFFF_FFEC, 32'hFFFF_FFFF}, "signed div0 R7");
        @(negedge clk);
        issue(2'b10, 32'h0000_1234, 32'd0);
        finish_op(DIV_LAT, {32'h0000_1234, 32'hFFFF_FFFF}, "unsigned div0 R7");

        // R8 abort: divide replaced by a multiply mid-flight
        @(negedge clk);
        issue(2'b10, 32'd1000, 32'd3);
        repeat (4) @(posedge clk);
        #1 issue(2'b01, 32'hFFFF_FFFE, 32'd9);
        finish_op(MUL_LAT, model(32'hFFFF_FFFE, 32'd9, 1'b0, 1'b1), "abort restart R8");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule